// File: doc/BRIEF.md
# Paged Dual-Read Data Store

This block holds the working data of a signal-processing datapath and serves two operands per cycle. The store has three regions: a 200-word by 16-bit read/write RAM, a 128-word by 16-bit constant table, and four 16-bit general registers. Two read buses, X and Y, each pick a region through a 2-bit page field. The offset inside the region comes from a pointer register. Two pointers address the RAM, and a third pointer addresses the constant table. When the page selects the general registers, a separate 2-bit field on that bus names the register.

Each cycle the block accepts a read on X, a read on Y, at most one write, and at most one pointer command. The pointer command can load, increment or decrement one pointer, and every pointer wraps inside its own region. A write takes the same page encoding as the reads, so a RAM write lands at the location named by the chosen RAM pointer. Read results are registered and appear on the buses one cycle after the request. They are meant to feed a multiplier and an ALU directly.

Top module: `paged_data_store`

## Requirements
- R1: While reset is asserted, and on the first read after reset, both read buses hold 0; all pointers and general registers reset to 0.
- R2: Page encoding is 0 = RAM at RAM pointer 0, 1 = RAM at RAM pointer 1, 2 = constant table at the table pointer, 3 = general register chosen by the bus's register-select field. The data selected at a clock edge appears on that bus after that same edge and holds for one cycle.
- R3: The pointer commands are: 0 hold, 1 load, 2 increment, 3 decrement. The pointer target is 0 = RAM pointer 0, 1 = RAM pointer 1, 2 = table pointer, 3 = none. Increment wraps from 199 to 0 for the RAM pointers and from 127 to 0 for the table pointer. Decrement wraps the other way.
- R4: A load whose value is not below the depth of the target region (200 for RAM, 128 for the table) leaves the pointer unchanged.
- R5: A pointer command changes the pointer at the clock edge. A read or write presented in the same cycle uses the old pointer value.
- R6: A write on page 0 or 1 stores into RAM at the chosen pointer. A write on page 3 stores into the general register named by the write's register-select field. Reads presented from the next cycle onward see the new value.
- R7: When a read and a write reach the same RAM word in the same cycle, the read returns the word's previous contents.
- R8: A write on page 2 changes nothing: no RAM word and no general register is altered.
- R9: Constant-table word i holds (i × 40503 + 4660) mod 65536.
- R10: X and Y are independent. Both can read any page and any location in the same cycle, including the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| xPage | input | 2 | Page select for read bus X |
| xGsel | input | 2 | General-register index for bus X when its page is 3 |
| yPage | input | 2 | Page select for read bus Y |
| yGsel | input | 2 | General-register index for bus Y when its page is 3 |
| wrEn | input | 1 | Write enable |
| wrPage | input | 2 | Page select for the write |
| wrGsel | input | 2 | General-register index for a page-3 write |
| wrData | input | 16 | Write data |
| ptrSel | input | 2 | Pointer targeted by the pointer command |
| ptrOp | input | 2 | Pointer command |
| ptrVal | input | 8 | Value used by a load command |
| xData | output | 16 | Registered read data, bus X |
| yData | output | 16 | Registered read data, bus Y |

## Verification
Each read result is due one edge after its request. A write or pointer change becomes visible on a bus two edges after it is presented: one edge to update the state, and one edge to register the read that sees it. The bench drives every input on the falling edge. A behavioural model then computes the bus values that the next rising edge must produce, using the pointers and memory contents from before that edge. The bench compares both buses at the next falling edge. The model applies writes and pointer commands only after it has computed those reads, which gives the same-cycle old-value and old-pointer rules without any special case in the comparison.

// File: rtl/dstore_pkg.sv
`timescale 1ns/1ps
package dstore_pkg;
  parameter int DW        = 16;
  parameter int RAM_DEPTH = 200;
  parameter int ROM_DEPTH = 128;
  parameter int GR_N      = 4;
  parameter int ROM_MUL   = 40503;
  parameter int ROM_ADD   = 4660;

  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int ROM_AW = $clog2(ROM_DEPTH);
  localparam int GR_AW  = $clog2(GR_N);
  localparam int LOAD_W = (RAM_AW > ROM_AW) ? RAM_AW : ROM_AW;

  typedef enum logic [1:0] {PG_RAM0, PG_RAM1, PG_ROM, PG_GREG} page_e;
  typedef enum logic [1:0] {OP_HOLD, OP_LOAD, OP_INC, OP_DEC} ptrOp_e;
  typedef enum logic [1:0] {SEL_RAM0, SEL_RAM1, SEL_ROM, SEL_NONE} ptrSel_e;
  typedef enum logic [1:0] {SRC_RAM, SRC_ROM, SRC_GR} src_e;

  typedef struct packed {
    logic              ramWe;
    logic [RAM_AW-1:0] ramWa;
    logic              grWe;
    logic [GR_AW-1:0]  grWa;
    src_e              xSrc;
    logic [RAM_AW-1:0] xRa;
    logic [GR_AW-1:0]  xGr;
    src_e              ySrc;
    logic [RAM_AW-1:0] yRa;
    logic [GR_AW-1:0]  yGr;
    logic [ROM_AW-1:0] romA;
  } memStrobe_t;

  function automatic logic [DW-1:0] romWord(input logic [ROM_AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'(ROM_MUL) + 32'(ROM_ADD);
    return t[DW-1:0];
  endfunction
endpackage

// File: rtl/dstore_ctrl.sv
`timescale 1ns/1ps
module dstore_ctrl
  import dstore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  page_e             xPage,
  input  logic [GR_AW-1:0]  xGsel,
  input  page_e             yPage,
  input  logic [GR_AW-1:0]  yGsel,
  input  logic              wrEn,
  input  page_e             wrPage,
  input  logic [GR_AW-1:0]  wrGsel,
  input  ptrSel_e           ptrSel,
  input  ptrOp_e            ptrOp,
  input  logic [LOAD_W-1:0] ptrVal,
  output memStrobe_t        strb
);
  localparam logic [RAM_AW-1:0] RAM_LAST = RAM_AW'(RAM_DEPTH - 1);
  localparam logic [ROM_AW-1:0] ROM_LAST = ROM_AW'(ROM_DEPTH - 1);

  logic [RAM_AW-1:0] ramPtr [2];
  logic [ROM_AW-1:0] romPtr;
  logic ramLoadOk, romLoadOk;

  assign ramLoadOk = {1'b0, ptrVal} < (LOAD_W+1)'(RAM_DEPTH);
  assign romLoadOk = {1'b0, ptrVal} < (LOAD_W+1)'(ROM_DEPTH);

  for (genvar g = 0; g < 2; g++) begin : gRamPtr
    logic [RAM_AW-1:0] ptr;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ptr <= '0;
      else if (ptrSel == ptrSel_e'(g)) begin
        case (ptrOp)
          OP_LOAD: if (ramLoadOk) ptr <= ptrVal[RAM_AW-1:0];
          OP_INC:  ptr <= (ptr == RAM_LAST) ? '0 : ptr + 1'b1;
          OP_DEC:  ptr <= (ptr == '0) ? RAM_LAST : ptr - 1'b1;
          default: ;
        endcase
      end
    end
    assign ramPtr[g] = ptr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) romPtr <= '0;
    else if (ptrSel == SEL_ROM) begin
      case (ptrOp)
        OP_LOAD: if (romLoadOk) romPtr <= ptrVal[ROM_AW-1:0];
        OP_INC:  romPtr <= (romPtr == ROM_LAST) ? '0 : romPtr + 1'b1;
        OP_DEC:  romPtr <= (romPtr == '0) ? ROM_LAST : romPtr - 1'b1;
        default: ;
      endcase
    end
  end

  function automatic src_e srcOf(input page_e p);
    case (p)
      PG_ROM:  return SRC_ROM;
      PG_GREG: return SRC_GR;
      default: return SRC_RAM;
    endcase
  endfunction

  always_comb begin
    strb.ramWe = wrEn && (wrPage == PG_RAM0 || wrPage == PG_RAM1);
    strb.ramWa = ramPtr[wrPage[0]];
    strb.grWe  = wrEn && (wrPage == PG_GREG);
    strb.grWa  = wrGsel;
    strb.xSrc  = srcOf(xPage);
    strb.xRa   = ramPtr[xPage[0]];
    strb.xGr   = xGsel;
    strb.ySrc  = srcOf(yPage);
    strb.yRa   = ramPtr[yPage[0]];
    strb.yGr   = yGsel;
    strb.romA  = romPtr;
  end

  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ramPtr[0] <= RAM_LAST && ramPtr[1] <= RAM_LAST && romPtr <= ROM_LAST);

  a_r3_inc_wraps: assert property (@(posedge clk) disable iff (!rstN)
    ptrSel == SEL_RAM0 && ptrOp == OP_INC && ramPtr[0] == RAM_LAST |=> ramPtr[0] == '0);

  a_r3_dec_wraps: assert property (@(posedge clk) disable iff (!rstN)
    ptrSel == SEL_ROM && ptrOp == OP_DEC && romPtr == '0 |=> romPtr == ROM_LAST);

  a_r4_bad_load_kept: assert property (@(posedge clk) disable iff (!rstN)
    ptrSel == SEL_RAM1 && ptrOp == OP_LOAD && !ramLoadOk |=> $stable(ramPtr[1]));

  a_r8_rom_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrPage == PG_ROM |-> !strb.ramWe && !strb.grWe);
endmodule

// File: rtl/dstore_dpath.sv
`timescale 1ns/1ps
module dstore_dpath
  import dstore_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  memStrobe_t    strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] xData,
  output logic [DW-1:0] yData
);
  logic [DW-1:0] ram [RAM_DEPTH];
  logic [GR_N-1:0][DW-1:0] gr;
  logic [DW-1:0] romOut, xNext, yNext;

  always_ff @(posedge clk) begin
    if (strb.ramWe) ram[strb.ramWa] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gr <= '0;
    else if (strb.grWe) gr[strb.grWa] <= wrData;
  end

  assign romOut = romWord(strb.romA);

  always_comb begin
    case (strb.xSrc)
      SRC_RAM: xNext = ram[strb.xRa];
      SRC_ROM: xNext = romOut;
      default: xNext = gr[strb.xGr];
    endcase
    case (strb.ySrc)
      SRC_RAM: yNext = ram[strb.yRa];
      SRC_ROM: yNext = romOut;
      default: yNext = gr[strb.yGr];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xData <= '0;
      yData <= '0;
    end else begin
      xData <= xNext;
      yData <= yNext;
    end
  end

  a_r7_read_old: assert property (@(posedge clk) disable iff (!rstN)
    strb.ramWe && strb.xSrc == SRC_RAM && strb.xRa == strb.ramWa
    |=> xData == $past(ram[strb.ramWa]));

  a_r6_gr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.grWe |=> $stable(gr));

  a_r6_single_target: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.ramWe && strb.grWe));
endmodule

// File: rtl/paged_data_store.sv
`timescale 1ns/1ps
module paged_data_store
  import dstore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        xPage,
  input  logic [GR_AW-1:0]  xGsel,
  input  logic [1:0]        yPage,
  input  logic [GR_AW-1:0]  yGsel,
  input  logic              wrEn,
  input  logic [1:0]        wrPage,
  input  logic [GR_AW-1:0]  wrGsel,
  input  logic [DW-1:0]     wrData,
  input  logic [1:0]        ptrSel,
  input  logic [1:0]        ptrOp,
  input  logic [LOAD_W-1:0] ptrVal,
  output logic [DW-1:0]     xData,
  output logic [DW-1:0]     yData
);
  memStrobe_t strb;

  dstore_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .xPage  (page_e'(xPage)),
    .xGsel  (xGsel),
    .yPage  (page_e'(yPage)),
    .yGsel  (yGsel),
    .wrEn   (wrEn),
    .wrPage (page_e'(wrPage)),
    .wrGsel (wrGsel),
    .ptrSel (ptrSel_e'(ptrSel)),
    .ptrOp  (ptrOp_e'(ptrOp)),
    .ptrVal (ptrVal),
    .strb   (strb)
  );

  dstore_dpath i_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .xData  (xData),
    .yData  (yData)
  );

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> xData == '0 && yData == '0);
endmodule

// File: tb/test_paged_data_store.sv
`timescale 1ns/1ps
module test_paged_data_store;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] xPage = 2'd3, xGsel = 2'd0, yPage = 2'd3, yGsel = 2'd0;
  logic wrEn = 1'b0;
  logic [1:0] wrPage = 2'd0, wrGsel = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [1:0] ptrSel = 2'd3, ptrOp = 2'd0;
  logic [7:0] ptrVal = 8'd0;
  logic [15:0] xData, yData;

  always #2.5 clk = ~clk;

  paged_data_store i_paged_data_store (
    .clk(clk), .rstN(rstN), .xPage(xPage), .xGsel(xGsel), .yPage(yPage), .yGsel(yGsel),
    .wrEn(wrEn), .wrPage(wrPage), .wrGsel(wrGsel), .wrData(wrData),
    .ptrSel(ptrSel), .ptrOp(ptrOp), .ptrVal(ptrVal), .xData(xData), .yData(yData)
  );

  int nChk = 0, nFail = 0;
  int mram [200];
  int mgr [4];
  int p0 = 0, p1 = 0, pr = 0;
  int expX = 0, expY = 0;
  bit armed = 0;
  string tag = "";

  function automatic int romW(int i);
    return (i * 40503 + 4660) & 16'hFFFF;
  endfunction

  function automatic int rd(int pg, int gs);
    case (pg)
      0: return mram[p0];
      1: return mram[p1];
      2: return romW(pr);
      default: return mgr[gs];
    endcase
  endfunction

  function automatic int ptrNext(int p, int depth, int op, int val);
    case (op)
      1: return (val < depth) ? val : p;
      2: return (p == depth - 1) ? 0 : p + 1;
      3: return (p == 0) ? depth - 1 : p - 1;
      default: return p;
    endcase
  endfunction

  task automatic check(string t, logic [15:0] act, int exp);
    nChk++;
    if (act !== 16'(exp)) begin
      nFail++;
      $display("FAIL %s: got %h expected %h at %0t", t, act, 16'(exp), $time);
    end
  endtask

  task automatic step(string t, int xp, int xg, int yp, int yg,
                      int we, int wp, int wg, int wd, int ps, int po, int pv);
    @(negedge clk);
    if (armed) begin
      check({tag, " busX"}, xData, expX);
      check({tag, " busY"}, yData, expY);
    end
    xPage = 2'(xp); xGsel = 2'(xg); yPage = 2'(yp); yGsel = 2'(yg);
    wrEn = 1'(we); wrPage = 2'(wp); wrGsel = 2'(wg); wrData = 16'(wd);
    ptrSel = 2'(ps); ptrOp = 2'(po); ptrVal = 8'(pv);
    expX = rd(xp, xg);
    expY = rd(yp, yg);
    if (we != 0) begin
      if (wp == 0) mram[p0] = wd & 16'hFFFF;
      else if (wp == 1) mram[p1] = wd & 16'hFFFF;
      else if (wp == 3) mgr[wg] = wd & 16'hFFFF;
    end
    case (ps)
      0: p0 = ptrNext(p0, 200, po, pv);
      1: p1 = ptrNext(p1, 200, po, pv);
      2: pr = ptrNext(pr, 128, po, pv);
      default: ;
    endcase
    tag = t;
    armed = 1;
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mgr[i] = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 reset busX", xData, 0);
      check("R1 reset busY", yData, 0);
    end
    rstN = 1'b1;
    // R1: registers read as zero after reset; R9 table word 0
    step("R1 greg", 3, 0, 3, 3, 0, 0, 0, 0, 3, 0, 0);
    step("R1 R9 table", 2, 0, 3, 1, 0, 0, 0, 0, 3, 0, 0);
    step("R1 greg2", 3, 2, 2, 0, 0, 0, 0, 0, 3, 0, 0);
    // R6: fill the RAM through pointer 0, incrementing it each cycle (wraps, R3)
    for (int i = 0; i < 200; i++)
      step("R6 fill", 2, 0, 3, 2, 1, 0, 0, (i * 313 + 17) ^ (i << 9), 0, 2, 0);
    // R9: walk the table pointer across its wrap while reading RAM word 0
    for (int i = 0; i < 130; i++)
      step("R9 table walk", 0, 0, 2, 0, 0, 0, 0, 0, 2, 2, 0);
    // R5: decrement in the same cycle as a read uses old pointer; R3 wraps 0 -> 199
    step("R5 old ptr", 0, 0, 1, 0, 0, 0, 0, 0, 0, 3, 0);
    step("R3 dec wrap", 0, 0, 1, 0, 0, 0, 0, 0, 3, 0, 0);
    step("R3 dec wrap2", 0, 0, 0, 0, 0, 0, 0, 0, 2, 3, 0);
    step("R3 table dec", 2, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0);
    // R4: out-of-range loads are dropped
    step("R4 ram load 230", 1, 0, 2, 0, 0, 0, 0, 0, 1, 1, 230);
    step("R4 table load 200", 1, 0, 2, 0, 0, 0, 0, 0, 2, 1, 200);
    step("R4 table load 128", 1, 0, 2, 0, 0, 0, 0, 0, 2, 1, 128);
    step("R4 after", 1, 0, 2, 0, 0, 0, 0, 0, 1, 1, 199);
    step("R3 load edge", 1, 0, 2, 0, 0, 0, 0, 0, 2, 1, 127);
    step("R3 load ok", 1, 0, 2, 0, 0, 0, 0, 0, 1, 1, 50);
    // R7: read and write hit the same word together
    step("R7 pre", 1, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0);
    step("R7 collide", 1, 0, 1, 0, 1, 1, 0, 16'hBEEF, 3, 0, 0);
    step("R7 new data", 1, 0, 1, 0, 0, 0, 0, 0, 3, 0, 0);
    step("R7 new data2", 0, 0, 1, 0, 1, 0, 0, 16'h0F0F, 3, 0, 0);
    step("R7 p0 write", 0, 0, 1, 0, 0, 0, 0, 0, 3, 0, 0);
    // R6: general register writes, then R8 table-page writes dropped
    for (int k = 0; k < 4; k++)
      step("R6 greg write", 3, k, 3, (k + 3) % 4, 1, 3, k, 16'hA000 + k * 16'h111, 3, 0, 0);
    step("R8 table write", 3, 1, 1, 0, 1, 2, 1, 16'h1234, 3, 0, 0);
    step("R8 table write2", 0, 0, 2, 0, 1, 2, 2, 16'h5678, 3, 0, 0);
    for (int k = 0; k < 4; k++)
      step("R8 unchanged", 3, k, 1, 0, 0, 0, 0, 0, 3, 0, 0);
    step("R8 ram unchanged", 0, 0, 1, 0, 0, 0, 0, 0, 3, 0, 0);
    // R10 / R2: mixed traffic on both buses
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step("R2 R10 mixed", r & 3, (r >> 2) & 3, (r >> 4) & 3, (r >> 6) & 3,
           ((r >> 8) & 3) != 0 ? 1 : 0, (r >> 10) & 3, (r >> 12) & 3, $urandom & 16'hFFFF,
           (r >> 14) & 3, (r >> 16) & 3, (r >> 18) & 255);
    end
    step("R2 drain", 3, 0, 3, 0, 0, 0, 0, 0, 3, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule